// File: doc/BRIEF.md
# Tagged Split-Transaction Read Bus

This block joins several read requesters to one memory responder over a bus with two channels. A read takes two bus transactions. In the first, the requester drives an address and a tag on the address channel. In the second, the memory side drives the data and the same tag on the data channel. The address channel is free again as soon as the address has been accepted, so other requesters can use it while memory is busy. The data channel is driven only by the memory side. In a single cycle the two channels can carry different reads.

A tag is made of the requester index followed by one sequence bit. Each requester can therefore have at most two reads outstanding. When several requesters want the address channel in the same cycle, the one with the lowest index wins. A requester that loses keeps its request and address unchanged until it is granted. The memory responder queues pending reads and answers them in the order they were accepted, after a fixed latency. Each requester takes only the data whose tag it owns and is still waiting for, and that tag then becomes free again.

Top module: `split_read_bus`

## Requirements
- R1: After reset, `abus_valid`, `dbus_valid`, `req_grant` (with no request) and `rsp_valid` are all low.
- R2: A request granted in a cycle appears on the address channel in the next cycle. That cycle shows `abus_valid` high, the request's address on `abus_addr`, and on `abus_tag` the requester index in the upper bits with the sequence bit in bit 0.
- R3: At most one request is granted per cycle. Among the requesters that hold a free tag, the one with the lowest index is granted.
- R4: A requester uses sequence bit 0 when that tag is free and sequence bit 1 otherwise. While both of its tags are outstanding, it is not granted.
- R5: The data for a read appears on the data channel exactly `LAT` cycles after its address cycle. It carries the same tag, and `dbus_data` = {`addr` XOR `SALT`, `addr`} (upper half XORed, lower half plain).
- R6: Reads return on the data channel in the order in which they were granted, from all requesters together. The address channel can carry a new read in the same cycle as the data channel returns an older one.
- R7: `rsp_valid[i]` is high only when `dbus_valid` is high, the tag's upper bits equal i, and that tag is outstanding for requester i. The tag can be granted again from the cycle after the data cycle.
- R8: The bus is not held during memory latency. A second requester can be granted in the cycle right after the first requester's grant, before any data has returned.
- R9: A grant is given only to a requester whose `req_valid` is high. A requester that is not granted keeps `req_valid` and its address stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_REQ | Read request from each requester |
| req_addr | input | N_REQ*ADDR_W | Address of each requester, requester i at bits [i*ADDR_W +: ADDR_W] |
| req_grant | output | N_REQ | The address phase of the requester is accepted this cycle |
| abus_valid | output | 1 | Address channel is busy with a transaction |
| abus_addr | output | ADDR_W | Address on the address channel |
| abus_tag | output | TAG_W | Tag on the address channel {index, seq} |
| dbus_valid | output | 1 | Data channel is busy with a transaction |
| dbus_tag | output | TAG_W | Tag on the data channel |
| dbus_data | output | 2*ADDR_W | Read data on the data channel |
| rsp_valid | output | N_REQ | Requester i takes the data on the data channel |

## Verification
The grant is combinational. It is checked in the same cycle the request is driven, after the inputs settle and before the clock edge. The address phase is checked one cycle after that grant. The data phase is due exactly `LAT` cycles after the address cycle. The driver records this due cycle for each accepted read and places the item in the scoreboard queue. The monitor compares tag, data, cycle and `rsp_valid` when the data channel is valid. The bench's model of which tags are outstanding frees a tag one clock edge after its data cycle. This matches the cycle in which R7 lets the tag be granted again.

// File: rtl/split_rd_pkg.sv
package split_rd_pkg;

   typedef enum logic {
      SLOT_FREE = 1'b0,
      SLOT_BUSY = 1'b1
   } slot_t;

   localparam int SEQ_SLOTS = 2;

endpackage

// File: rtl/srb_arbiter.sv
module srb_arbiter #(
   parameter int N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   for (genvar i = 0; i < N; i++) begin : g_port
      if (i == 0) begin : g_top
         assign gnt[i] = req[i];
      end else begin : g_rest
         assign gnt[i] = req[i] & ~(|req[i-1:0]);
      end
   end
endmodule

// File: rtl/srb_tag_tracker.sv
module srb_tag_tracker
   import split_rd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic alloc,
   input  logic free_en,
   input  logic free_seq,
   output logic can_alloc,
   output logic alloc_seq,
   output logic free_hit
);
   slot_t slot [SEQ_SLOTS];

   assign can_alloc = (slot[0] == SLOT_FREE) || (slot[1] == SLOT_FREE);
   assign alloc_seq = (slot[0] == SLOT_FREE) ? 1'b0 : 1'b1;
   assign free_hit  = free_en && (slot[free_seq] == SLOT_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SEQ_SLOTS; s++) slot[s] <= SLOT_FREE;
      end else begin
         for (int s = 0; s < SEQ_SLOTS; s++) begin
            if (alloc && (alloc_seq == 1'(s)))
               slot[s] <= SLOT_BUSY;
            else if (free_hit && (free_seq == 1'(s)))
               slot[s] <= SLOT_FREE;
         end
      end
   end
endmodule

// File: rtl/srb_mem_resp.sv
module srb_mem_resp #(
   parameter int                ADDR_W = 8,
   parameter int                TAG_W  = 2,
   parameter int                DEPTH  = 4,
   parameter int                LAT    = 3,
   parameter logic [ADDR_W-1:0] SALT   = 'hA5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [ADDR_W-1:0]   push_addr,
   input  logic [TAG_W-1:0]    push_tag,
   output logic                full,
   output logic                dbus_valid,
   output logic [TAG_W-1:0]    dbus_tag,
   output logic [2*ADDR_W-1:0] dbus_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(LAT) + 1;

   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [TAG_W-1:0]  e_tag  [DEPTH];
   logic [CNT_W-1:0]  e_cnt  [DEPTH];
   logic [DEPTH-1:0]  e_vld;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [PTR_W:0]    count;
   logic              pop;

   assign full = (count == (PTR_W+1)'(DEPTH));
   assign pop  = e_vld[rd_ptr] && (e_cnt[rd_ptr] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         count      <= '0;
         e_vld      <= '0;
         dbus_valid <= 1'b0;
         dbus_tag   <= '0;
         dbus_data  <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            e_addr[k] <= '0;
            e_tag[k]  <= '0;
            e_cnt[k]  <= '0;
         end
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            if (push && (wr_ptr == PTR_W'(k))) begin
               e_addr[k] <= push_addr;
               e_tag[k]  <= push_tag;
               e_cnt[k]  <= CNT_W'(LAT - 1);
               e_vld[k]  <= 1'b1;
            end else if (pop && (rd_ptr == PTR_W'(k))) begin
               e_vld[k]  <= 1'b0;
            end else if (e_vld[k] && (e_cnt[k] != '0)) begin
               e_cnt[k]  <= e_cnt[k] - 1'b1;
            end
         end
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count      <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
         dbus_valid <= pop;
         if (pop) begin
            dbus_tag  <= e_tag[rd_ptr];
            dbus_data <= {e_addr[rd_ptr] ^ SALT, e_addr[rd_ptr]};
         end
      end
   end
endmodule

// File: rtl/split_read_bus.sv
module split_read_bus #(
   parameter int                N_REQ  = 2,
   parameter int                ADDR_W = 8,
   parameter int                DEPTH  = 4,
   parameter int                LAT    = 3,
   parameter logic [ADDR_W-1:0] SALT   = 'hA5,
   localparam int               ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
   localparam int               TAG_W  = ID_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_REQ-1:0]          req_valid,
   input  logic [N_REQ*ADDR_W-1:0]   req_addr,
   output logic [N_REQ-1:0]          req_grant,
   output logic                      abus_valid,
   output logic [ADDR_W-1:0]         abus_addr,
   output logic [TAG_W-1:0]          abus_tag,
   output logic                      dbus_valid,
   output logic [TAG_W-1:0]          dbus_tag,
   output logic [2*ADDR_W-1:0]       dbus_data,
   output logic [N_REQ-1:0]          rsp_valid
);
   if (N_REQ < 2) begin : g_bad_nreq
      $error("split_read_bus: N_REQ must be at least 2");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("split_read_bus: LAT must be at least 1");
   end
   if (DEPTH < 2 * N_REQ || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("split_read_bus: DEPTH must be a power of two >= 2*N_REQ");
   end

   logic [N_REQ-1:0] can_alloc, alloc_seq, eligible, arb_gnt, hit, free_hit;
   logic             q_full;
   logic [ADDR_W-1:0] sel_addr;
   logic [ID_W-1:0]   sel_id;
   logic              sel_seq;

   assign eligible  = req_valid & can_alloc;
   assign req_grant = arb_gnt & {N_REQ{~q_full}};

   srb_arbiter #(.N(N_REQ)) u_arb (
      .req (eligible),
      .gnt (arb_gnt)
   );

   for (genvar i = 0; i < N_REQ; i++) begin : g_req
      assign hit[i]       = dbus_valid && (dbus_tag[TAG_W-1:1] == ID_W'(i));
      assign rsp_valid[i] = free_hit[i];
      srb_tag_tracker u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (req_grant[i]),
         .free_en   (hit[i]),
         .free_seq  (dbus_tag[0]),
         .can_alloc (can_alloc[i]),
         .alloc_seq (alloc_seq[i]),
         .free_hit  (free_hit[i])
      );
   end

   always_comb begin
      sel_addr = '0;
      sel_id   = '0;
      sel_seq  = 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
         if (req_grant[i]) begin
            sel_addr = req_addr[i*ADDR_W +: ADDR_W];
            sel_id   = ID_W'(i);
            sel_seq  = alloc_seq[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abus_valid <= 1'b0;
         abus_addr  <= '0;
         abus_tag   <= '0;
      end else begin
         abus_valid <= |req_grant;
         if (|req_grant) begin
            abus_addr <= sel_addr;
            abus_tag  <= {sel_id, sel_seq};
         end
      end
   end

   srb_mem_resp #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W),
      .DEPTH  (DEPTH),
      .LAT    (LAT),
      .SALT   (SALT)
   ) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (|req_grant),
      .push_addr  (sel_addr),
      .push_tag   ({sel_id, sel_seq}),
      .full       (q_full),
      .dbus_valid (dbus_valid),
      .dbus_tag   (dbus_tag),
      .dbus_data  (dbus_data)
   );
endmodule

// File: rtl/split_read_bus_chk.sv
module split_read_bus_chk #(
   parameter int N_REQ  = 2,
   parameter int ADDR_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_REQ-1:0]        req_valid,
   input logic [N_REQ*ADDR_W-1:0] req_addr,
   input logic [N_REQ-1:0]        req_grant,
   input logic                    abus_valid,
   input logic                    dbus_valid,
   input logic [N_REQ-1:0]        rsp_valid
);
   logic [7:0] out_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_cnt <= '0;
      else        out_cnt <= out_cnt + 8'(abus_valid) - 8'(dbus_valid);
   end

   p_rst_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!abus_valid && !dbus_valid && rsp_valid == '0));

   p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_grant));

   p_grant_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant & ~req_valid) == '0);

   p_abus_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_grant) |=> abus_valid);

   p_abus_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_grant) |=> !abus_valid);

   p_rsp_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|rsp_valid) |-> (dbus_valid && $onehot(rsp_valid)));

   p_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= 8'(2 * N_REQ));

   for (genvar k = 0; k < N_REQ; k++) begin : g_hold
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[k] && !req_grant[k]) |=>
            (req_valid[k] && $stable(req_addr[k*ADDR_W +: ADDR_W])));
   end
endmodule

bind split_read_bus split_read_bus_chk #(
   .N_REQ  (N_REQ),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .req_grant  (req_grant),
   .abus_valid (abus_valid),
   .dbus_valid (dbus_valid),
   .rsp_valid  (rsp_valid)
);

// File: tb/split_read_bus_tb.sv
module split_read_bus_tb;
   localparam int N_REQ  = 2;
   localparam int ADDR_W = 8;
   localparam int LAT    = 3;
   localparam logic [ADDR_W-1:0] SALT = 8'hA5;
   localparam int TAG_W  = 2;

   typedef struct {
      int               port;
      int               seq;
      logic [ADDR_W-1:0] addr;
      int               due;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_REQ-1:0]        req_valid = '0;
   logic [N_REQ*ADDR_W-1:0] req_addr  = '0;
   logic [N_REQ-1:0]        req_grant;
   logic                    abus_valid, dbus_valid;
   logic [ADDR_W-1:0]       abus_addr;
   logic [TAG_W-1:0]        abus_tag, dbus_tag;
   logic [2*ADDR_W-1:0]     dbus_data;
   logic [N_REQ-1:0]        rsp_valid;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit busy_m [N_REQ][2];
   bit clr_pend = 0;
   int clr_p, clr_s;
   exp_t q[$];

   always #2.5 clk = ~clk;

   split_read_bus #(.N_REQ(N_REQ), .ADDR_W(ADDR_W), .DEPTH(4), .LAT(LAT), .SALT(SALT)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_grant(req_grant), .abus_valid(abus_valid), .abus_addr(abus_addr),
      .abus_tag(abus_tag), .dbus_valid(dbus_valid), .dbus_tag(dbus_tag),
      .dbus_data(dbus_data), .rsp_valid(rsp_valid)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (clr_pend) begin
         busy_m[clr_p][clr_s] = 0;
         clr_pend = 0;
      end
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // expected grant model (R3, R4)
   always @(negedge clk) begin
      if (rst_n) begin
         #1;
         if (|req_valid) begin
            logic [N_REQ-1:0] eg;
            eg = '0;
            for (int p = 0; p < N_REQ; p++) begin
               if (eg == '0 && req_valid[p] && !(busy_m[p][0] && busy_m[p][1]))
                  eg[p] = 1'b1;
            end
            check(req_grant == eg, "R3/R4 grant", 32'(req_grant), 32'(eg));
         end
      end
   end

   // scoreboard monitor (R5, R6, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (dbus_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R6 unexpected data", 32'(dbus_tag), 32'hFFFF);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(dbus_tag == TAG_W'({e.port[0], e.seq[0]}), "R5 data tag", 32'(dbus_tag), 32'({e.port[0], e.seq[0]}));
               check(dbus_data == {e.addr ^ SALT, e.addr}, "R5 data value", 32'(dbus_data), 32'({e.addr ^ SALT, e.addr}));
               check(cyc == e.due, "R5/R6 data cycle", 32'(cyc), 32'(e.due));
               check(rsp_valid == N_REQ'(1 << e.port), "R7 rsp_valid", 32'(rsp_valid), 32'(1 << e.port));
               clr_p = e.port;
               clr_s = e.seq;
               clr_pend = 1;
            end
         end else begin
            check(rsp_valid == '0, "R7 rsp_valid idle", 32'(rsp_valid), 0);
         end
      end
   end

   // driver: pushes expected items into the scoreboard (R2, R8, R9)
   task automatic issue(input int p, input logic [ADDR_W-1:0] a);
      int s;
      exp_t e;
      @(negedge clk);
      req_valid[p] = 1'b1;
      req_addr[p*ADDR_W +: ADDR_W] = a;
      forever begin
         #2;
         if (req_grant[p]) break;
         @(negedge clk);
      end
      s = busy_m[p][0] ? 1 : 0;
      e.port = p; e.seq = s; e.addr = a; e.due = cyc + 1 + LAT;
      q.push_back(e);
      busy_m[p][s] = 1;
      @(negedge clk);
      req_valid[p] = 1'b0;
      check(abus_valid == 1'b1, "R2 abus_valid", 32'(abus_valid), 1);
      check(abus_addr == a, "R2 abus_addr", 32'(abus_addr), 32'(a));
      check(abus_tag == TAG_W'({p[0], s[0]}), "R2 abus_tag", 32'(abus_tag), 32'({p[0], s[0]}));
   endtask

   initial begin
      for (int p = 0; p < N_REQ; p++) begin busy_m[p][0] = 0; busy_m[p][1] = 0; end
      repeat (4) @(negedge clk);
      // R1 reset state
      check(abus_valid == 0, "R1 abus_valid", 32'(abus_valid), 0);
      check(dbus_valid == 0, "R1 dbus_valid", 32'(dbus_valid), 0);
      check(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
      check(req_grant == 0, "R1 req_grant", 32'(req_grant), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single read (R2, R5)
      issue(0, 8'h12);
      repeat (LAT + 3) @(negedge clk);

      // simultaneous requests: port 0 wins, port 1 follows next cycle (R3, R8, R9)
      fork
         issue(0, 8'h34);
         issue(1, 8'h56);
      join
      repeat (LAT + 3) @(negedge clk);

      // port 0 fills both tags and stalls on a third; port 1 runs alongside (R4, R6, R7)
      fork
         begin
            issue(0, 8'h01);
            issue(0, 8'h02);
            issue(0, 8'h03);
            issue(0, 8'h04);
         end
         begin
            issue(1, 8'hF0);
            issue(1, 8'hE1);
            issue(1, 8'hD2);
         end
      join
      repeat (LAT + 4) @(negedge clk);

      // all reads returned (R6)
      check(q.size() == 0, "R6 scoreboard drained", 32'(q.size()), 0);
      check(dbus_valid == 0 && abus_valid == 0, "R1 idle after drain", 32'({abus_valid, dbus_valid}), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule